// File: doc/BRIEF.md
# Run-Length Configuration Bit Decoder

This block turns a stream of compressed code bytes into a serial stream of configuration bits, one bit per clock, for a downstream configuration shifter. Each code byte stands for a run of identical bits. The run may be followed by a single closing bit of the opposite value. A compile-time parameter `MAX_ONES` sets where the code space is split between runs of ones and runs of zeros.

A producer offers bytes with a valid/ready handshake. The decoder takes one byte only when every bit of the previous byte has been delivered. A consumer pulls bits with a second valid/ready handshake. The byte values 0 and 255 are not part of the code map: they produce no bits and set a sticky format-error flag. A wrapping counter of accepted bytes is provided for debug.

Top module: `rlcd_top`

## Requirements
- R1: A code n with 1 <= n <= MAX_ONES expands to n one-bits followed by a single zero-bit.
- R2: The code MAX_ONES+1 expands to exactly MAX_ONES one-bits and has no closing bit.
- R3: A code n with MAX_ONES+2 <= n <= 254 expands to n-(MAX_ONES+2) zero-bits followed by a single one-bit.
- R4: The code MAX_ONES+2 expands to a single one-bit.
- R5: The codes 0 and 255 are accepted but emit no bits. They raise `fmt_err`, which stays high until reset.
- R6: `code_ready` is high only while no bit of the current code is pending. A byte is taken on a clock edge where `code_valid` and `code_ready` are both high. While bits are pending, offered bytes are not taken and the pending run is unchanged.
- R7: While `bit_valid` is high and `bit_ready` is low, `bit_valid` stays high and `bit_data` holds its value. A bit is consumed on each edge where both are high.
- R8: The first bit of an accepted code is valid in the cycle after the accepting edge. `code_ready` returns high in the cycle after the edge that consumes the last bit.
- R9: `accept_cnt` increases by one, wrapping, for every accepted byte, including the codes 0 and 255.
- R10: Reset (`rst_n` low, asynchronous) forces `code_ready`=1, `bit_valid`=0, `fmt_err`=0 and `accept_cnt`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| code_valid | input | 1 | Code byte offered |
| code_byte | input | 8 | Code byte value |
| code_ready | output | 1 | Decoder can take a code byte |
| bit_valid | output | 1 | Output bit available |
| bit_data | output | 1 | Output bit value |
| bit_ready | input | 1 | Consumer takes the output bit |
| fmt_err | output | 1 | Sticky flag: an unmapped code was received |
| accept_cnt | output | CNT_W | Wrapping count of accepted bytes |

## Verification
All results are due one register stage after the edge that causes them:
- the first bit of a code, `fmt_err` and the new `accept_cnt` after the accepting edge;
- `code_ready` after the edge that consumes the final bit.

The bench drives inputs and samples outputs on the falling edge. A value caused by a rising edge is therefore read half a cycle later. A bit is credited as consumed only when `bit_valid` and `bit_ready` were both high at the sample before that edge. Stalls are created by a pseudo-random `bit_ready` pattern. At each stall, the held bit is compared at the next sample.

// File: rtl/rlcd_pkg.sv
package rlcd_pkg;

  localparam int CODE_W = 8;
  localparam int CODE_TOP = (1 << CODE_W) - 1;

  typedef enum logic [1:0] {
    CLS_BAD       = 2'd0,
    CLS_ONES_TERM = 2'd1,
    CLS_ONES_ONLY = 2'd2,
    CLS_ZERO_TERM = 2'd3
  } rlcd_cls_e;

  typedef struct packed {
    logic [CODE_W-1:0] run_len;
    logic              run_val;
    logic              closer;
    logic              bad;
  } rlcd_cmd_t;

endpackage

// File: rtl/rlcd_rst_sync.sv
module rlcd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/rlcd_classify.sv
module rlcd_classify
  import rlcd_pkg::*;
#(
  parameter int MAX_ONES = 8
) (
  input  logic [CODE_W-1:0] code,
  output rlcd_cls_e         cls,
  output rlcd_cmd_t         cmd
);

  localparam logic [CODE_W-1:0] ONES_MAX  = CODE_W'(MAX_ONES);
  localparam logic [CODE_W-1:0] ONLY_CODE = CODE_W'(MAX_ONES + 1);
  localparam logic [CODE_W-1:0] ZERO_BASE = CODE_W'(MAX_ONES + 2);
  localparam logic [CODE_W-1:0] LAST_OK   = CODE_W'(CODE_TOP - 1);

  generate
    if (MAX_ONES < 1 || MAX_ONES > CODE_TOP - 3) begin : g_bad_param
      $error("MAX_ONES out of range");
    end
  endgenerate

  always_comb begin
    cls = CLS_BAD;
    if (code >= CODE_W'(1) && code <= ONES_MAX) begin
      cls = CLS_ONES_TERM;
    end else if (code == ONLY_CODE) begin
      cls = CLS_ONES_ONLY;
    end else if (code >= ZERO_BASE && code <= LAST_OK) begin
      cls = CLS_ZERO_TERM;
    end
  end

  always_comb begin
    cmd = '0;
    unique case (cls)
      CLS_ONES_TERM: begin
        cmd.run_len = code;
        cmd.run_val = 1'b1;
        cmd.closer  = 1'b1;
      end
      CLS_ONES_ONLY: begin
        cmd.run_len = code - CODE_W'(1);
        cmd.run_val = 1'b1;
        cmd.closer  = 1'b0;
      end
      CLS_ZERO_TERM: begin
        cmd.run_len = code - ZERO_BASE;
        cmd.run_val = 1'b0;
        cmd.closer  = 1'b1;
      end
      default: begin
        cmd.bad = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/rlcd_runner.sv
module rlcd_runner
  import rlcd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load_en,
  input  rlcd_cmd_t cmd,
  input  logic      bit_ready,
  output logic      bit_valid,
  output logic      bit_data,
  output logic      idle
);

  logic [CODE_W-1:0] left_q, left_d;
  logic              val_q, val_d;
  logic              close_q, close_d;
  logic              in_run;
  logic              fire;

  assign in_run    = (left_q != '0);
  assign bit_valid = in_run | close_q;
  assign bit_data  = in_run ? val_q : ~val_q;
  assign idle      = ~bit_valid;
  assign fire      = bit_valid & bit_ready;

  always_comb begin
    left_d  = left_q;
    val_d   = val_q;
    close_d = close_q;
    if (load_en) begin
      left_d  = cmd.run_len;
      val_d   = cmd.run_val;
      close_d = cmd.closer;
    end else if (fire) begin
      if (in_run) begin
        left_d = left_q - CODE_W'(1);
      end else begin
        close_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= '0;
      val_q   <= 1'b0;
      close_q <= 1'b0;
    end else begin
      left_q  <= left_d;
      val_q   <= val_d;
      close_q <= close_d;
    end
  end

  // R7: a stalled bit stays offered with the same value
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !bit_ready) |=> (bit_valid && $stable(bit_data)));

  // R6: a new code is only loaded when nothing is pending
  p_load_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> !bit_valid);

endmodule

// File: rtl/rlcd_accept_ctr.sv
module rlcd_accept_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_en,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc_en) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

  // R9: one step per accepted byte, wrapping
  p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inc_en |=> (count == $past(count) + CNT_W'(1)));

  // R9: no step without an accepted byte
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_en |=> $stable(count));

endmodule

// File: rtl/rlcd_top.sv
module rlcd_top
  import rlcd_pkg::*;
#(
  parameter int MAX_ONES = 8,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             code_valid,
  input  logic [7:0]       code_byte,
  output logic             code_ready,
  output logic             bit_valid,
  output logic             bit_data,
  input  logic             bit_ready,
  output logic             fmt_err,
  output logic [CNT_W-1:0] accept_cnt
);

  localparam logic [CODE_W-1:0] ONES_MAX  = CODE_W'(MAX_ONES);
  localparam logic [CODE_W-1:0] ONLY_CODE = CODE_W'(MAX_ONES + 1);
  localparam logic [CODE_W-1:0] ZERO_BASE = CODE_W'(MAX_ONES + 2);

  logic      rst_sync_n;
  logic      accept;
  logic      idle;
  logic      err_q, err_d;
  rlcd_cls_e cls;
  rlcd_cmd_t cmd;

  rlcd_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rlcd_classify #(.MAX_ONES(MAX_ONES)) u_cls (
    .code (code_byte),
    .cls  (cls),
    .cmd  (cmd)
  );

  rlcd_runner u_run (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load_en   (accept),
    .cmd       (cmd),
    .bit_ready (bit_ready),
    .bit_valid (bit_valid),
    .bit_data  (bit_data),
    .idle      (idle)
  );

  rlcd_accept_ctr #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .inc_en (accept),
    .count  (accept_cnt)
  );

  assign code_ready = idle;
  assign accept     = code_valid & idle;

  always_comb begin
    err_d = err_q;
    if (accept && cmd.bad) begin
      err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  assign fmt_err = err_q;

  // R5: error flag is sticky
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fmt_err |=> fmt_err);

  // R5: unmapped codes emit nothing and set the flag
  p_err_quiet_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (accept && (code_byte == 8'h00 || code_byte == 8'hFF))
      |=> (fmt_err && !bit_valid && code_ready));

  // R1: a ones-with-closer code starts with a one
  p_ones_first_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (accept && code_byte >= 8'd1 && code_byte <= ONES_MAX)
      |=> (bit_valid && bit_data));

  // R2: the ones-only code starts with a one
  p_only_first_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (accept && code_byte == ONLY_CODE) |=> (bit_valid && bit_data));

  // R3: a zero-run code with a non-empty run starts with a zero
  p_zero_first_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (accept && code_byte > ZERO_BASE && code_byte < 8'hFF)
      |=> (bit_valid && !bit_data));

  // R4: the base zero-run code is a lone one-bit
  p_single_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (accept && code_byte == ZERO_BASE) |=> (bit_valid && bit_data));

  // R6: no byte is offered as accepted while bits are pending
  p_busy_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bit_valid |-> !code_ready);

  // R8: after a mapped code is taken, a bit is on offer next cycle
  p_first_due_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (accept && cls != CLS_BAD) |=> bit_valid);

endmodule

// File: tb/sim_rlcd_top.sv
module sim_rlcd_top;

  localparam int M     = 8;
  localparam int CNT_W = 16;
  localparam int NVEC  = 9;

  // {code, length, body value, closing value, stall}
  localparam logic [18:0] VEC [NVEC] = '{
    {8'd1,   8'd2,   1'b1, 1'b0, 1'b0},
    {8'd5,   8'd6,   1'b1, 1'b0, 1'b1},
    {8'd8,   8'd9,   1'b1, 1'b0, 1'b0},
    {8'd9,   8'd8,   1'b1, 1'b1, 1'b1},
    {8'd10,  8'd1,   1'b1, 1'b1, 1'b0},
    {8'd11,  8'd2,   1'b0, 1'b1, 1'b1},
    {8'd30,  8'd21,  1'b0, 1'b1, 1'b0},
    {8'd254, 8'd245, 1'b0, 1'b1, 1'b1},
    {8'd3,   8'd4,   1'b1, 1'b0, 1'b0}
  };

  logic             clk;
  logic             rst_n;
  logic             code_valid;
  logic [7:0]       code_byte;
  logic             code_ready;
  logic             bit_valid;
  logic             bit_data;
  logic             bit_ready;
  logic             fmt_err;
  logic [CNT_W-1:0] accept_cnt;

  int   checks;
  int   failures;
  int   exp_acc;
  logic [7:0] lf;

  rlcd_top #(.MAX_ONES(M), .CNT_W(CNT_W)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .code_valid (code_valid),
    .code_byte  (code_byte),
    .code_ready (code_ready),
    .bit_valid  (bit_valid),
    .bit_data   (bit_data),
    .bit_ready  (bit_ready),
    .fmt_err    (fmt_err),
    .accept_cnt (accept_cnt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures = failures + 1;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    report();
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic next_stall();
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    return lf[0];
  endfunction

  // Called at a falling edge; offers a byte and returns one falling edge later.
  task automatic send_code(input logic [7:0] c);
    int guard = 0;
    while (!code_ready && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    code_valid = 1'b1;
    code_byte  = c;
    @(negedge clk);
    code_valid = 1'b0;
    exp_acc    = exp_acc + 1;
  endtask

  // Called at the falling edge after acceptance.
  task automatic drain(input string req, input int len, input logic body,
                       input logic last, input logic stall);
    int   got = 0;
    int   guard = 0;
    logic held = 1'b0;
    logic held_v = 1'b0;
    chk("R8 first bit due", int'(bit_valid), 1);
    while (got < len && guard < 2000) begin
      if (held) begin
        chk("R7 stalled bit kept", int'(bit_valid), 1);
        chk("R7 stalled value kept", int'(bit_data), int'(held_v));
      end
      bit_ready = stall ? next_stall() : 1'b1;
      held = 1'b0;
      if (bit_valid) begin
        if (bit_ready) begin
          chk(req, int'(bit_data), (got < len - 1) ? int'(body) : int'(last));
          got++;
        end else begin
          held   = 1'b1;
          held_v = bit_data;
        end
      end
      @(negedge clk);
      guard++;
    end
    chk("R8 ready after last bit", int'(code_ready), 1);
    chk("R8 no extra bit", int'(bit_valid), 0);
    bit_ready = 1'b1;
  endtask

  initial begin
    checks     = 0;
    failures   = 0;
    exp_acc    = 0;
    lf         = 8'h5A;
    rst_n      = 1'b0;
    code_valid = 1'b0;
    code_byte  = 8'h00;
    bit_ready  = 1'b1;
    repeat (3) @(negedge clk);

    // R10: reset state
    chk("R10 code_ready", int'(code_ready), 1);
    chk("R10 bit_valid", int'(bit_valid), 0);
    chk("R10 fmt_err", int'(fmt_err), 0);
    chk("R10 accept_cnt", int'(accept_cnt), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Vector table: R1 (ones + zero), R2 (ones only), R3 (zeros + one), R4 (lone one)
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] c;
      int         ln;
      c  = VEC[i][18:11];
      ln = int'(VEC[i][10:3]);
      send_code(c);
      if (c <= 8'(M))            drain("R1 bit value", ln, VEC[i][2], VEC[i][1], VEC[i][0]);
      else if (c == 8'(M + 1))   drain("R2 bit value", ln, VEC[i][2], VEC[i][1], VEC[i][0]);
      else if (c == 8'(M + 2))   drain("R4 bit value", ln, VEC[i][2], VEC[i][1], VEC[i][0]);
      else                       drain("R3 bit value", ln, VEC[i][2], VEC[i][1], VEC[i][0]);
      chk("R9 accept_cnt", int'(accept_cnt), exp_acc);
    end
    chk("R5 no error on mapped codes", int'(fmt_err), 0);

    // R6: byte offered while busy is not taken, run unchanged
    send_code(8'd30);
    bit_ready  = 1'b0;
    code_valid = 1'b1;
    code_byte  = 8'd5;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R6 ready low while busy", int'(code_ready), 0);
      chk("R6 count unchanged while busy", int'(accept_cnt), exp_acc);
      chk("R7 held zero while stalled", int'(bit_data), 0);
    end
    code_valid = 1'b0;
    drain("R6 run unchanged", 21, 1'b0, 1'b1, 1'b0);
    chk("R6 rejected byte not counted", int'(accept_cnt), exp_acc);

    // R5: unmapped codes
    send_code(8'h00);
    chk("R5 zero code sets flag", int'(fmt_err), 1);
    chk("R5 zero code emits nothing", int'(bit_valid), 0);
    chk("R5 zero code ready", int'(code_ready), 1);
    chk("R9 error code counted", int'(accept_cnt), exp_acc);
    send_code(8'hFF);
    chk("R5 255 emits nothing", int'(bit_valid), 0);
    chk("R9 second error code counted", int'(accept_cnt), exp_acc);
    send_code(8'd2);
    drain("R1 bit after error", 3, 1'b1, 1'b0, 1'b0);
    chk("R5 flag sticky", int'(fmt_err), 1);

    // R10: reset in mid-stream
    send_code(8'd40);
    rst_n = 1'b0;
    #1;
    chk("R10 mid-run bit_valid", int'(bit_valid), 0);
    chk("R10 mid-run fmt_err", int'(fmt_err), 0);
    chk("R10 mid-run accept_cnt", int'(accept_cnt), 0);
    chk("R10 mid-run code_ready", int'(code_ready), 1);
    @(negedge clk);
    rst_n   = 1'b1;
    exp_acc = 0;
    repeat (4) @(negedge clk);
    send_code(8'd9);
    drain("R2 after reset", 8, 1'b1, 1'b1, 1'b0);
    chk("R9 count after reset", int'(accept_cnt), exp_acc);

    report();
  end

endmodule